// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Write-Busy Polling

This block sits between a two-wire serial bus (one clock line, one open-drain data line) and a command engine. It samples both lines with the system clock through a synchronizer and a glitch filter. It finds start and stop conditions and shifts bytes in most significant bit first. It acknowledges by pulling the data line low through an active-low open-drain enable. It delivers each received command byte and data byte to the engine, and it shifts one read byte back out when the engine asks for a read.

A transaction starts with an address byte. The upper nibble of that byte is a fixed device type, set by a parameter that defaults to 0101b. The lower nibble must equal four strap pins. The engine raises `nv_busy` while it commits a write to nonvolatile storage. During that time the slave does not acknowledge its own address. A master can therefore poll with the address alone until it sees an acknowledge. Clock stretching, arbitration and general call are not supported.

Top module: `twi_poll_slave`

## Requirements
- R1: Until a start condition (SDA falling while SCL is high) has been seen after reset or after a stop, clocked bytes get no acknowledge and no byte is delivered.
- R2: After a start, the first byte is acknowledged only when its bits [7:4] equal the device type 0101b and its bits [3:0] equal `strap_addr`. On a mismatch, SDA stays released and every later byte is ignored (no acknowledge, no `rx_valid`) until the next start.
- R3: An acknowledge drives `sda_drive_low` high from the SCL falling edge that ends the eighth bit until the SCL falling edge that ends the ninth clock.
- R4: The byte after an accepted address is acknowledged and delivered MSB first on `rx_byte`, with a one-cycle `rx_valid` pulse and `rx_is_cmd` = 1.
- R5: Each byte after the command is delivered with `rx_is_cmd` = 0. It is acknowledged only when `data_ack_en` is high at the end of its eighth bit; otherwise the slave ignores the bus until the next start.
- R6: While `nv_busy` is high, the address byte is not acknowledged even when it matches. Once `nv_busy` is low, a matching address is acknowledged again.
- R7: When `read_req` is high as the command acknowledge ends, the slave sends `tx_byte` MSB first. Each bit changes after an SCL falling edge and is held through SCL high. The slave releases SDA for the ninth clock and does not drive SDA again until the next start, whatever the master's acknowledge bit.
- R8: A start seen in the middle of a byte ends the transaction and begins a new address reception.
- R9: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks has no effect on the transaction.
- R10: A stop condition (SDA rising while SCL is high) gives a one-cycle `bus_stop` pulse and leaves SDA released.
- R11: `sda_drive_low` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_drive_low | output | 1 | 1 pulls the data line low (open-drain enable) |
| strap_addr | input | 4 | Pin-strapped lower address nibble |
| nv_busy | input | 1 | Nonvolatile write in progress; address not acknowledged |
| data_ack_en | input | 1 | Engine accepts the data byte being received |
| read_req | input | 1 | Engine wants a read byte after the command |
| tx_byte | input | 8 | Read byte to transmit |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_byte | output | 8 | Received command or data byte |
| rx_is_cmd | output | 1 | 1 when `rx_byte` is the command byte |
| bus_stop | output | 1 | One-cycle pulse on a stop condition |

## Verification
A change on the bus pins reaches the controller after the synchronizer depth plus `FILT_CYCLES` system clocks. The controller acts on the next edge, so `sda_drive_low` moves about seven clocks after an SCL edge with the default parameters. The bench holds each SCL phase for twenty clocks. It changes SDA ten clocks into a low phase and samples acknowledges and read bits ten clocks into the high phase, so every sample falls well after the output has settled and well before the next bus edge. Received bytes are captured on the `rx_valid` strobe and compared after the byte's ninth clock.

// File: rtl/twi_poll_pkg.sv
package twi_poll_pkg;
   localparam int         BYTE_W       = 8;
   localparam logic [3:0] DEF_DEV_TYPE = 4'b0101;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECV,
      ST_ACK,
      ST_SEND,
      ST_SKIP
   } twi_state_e;
endpackage

// File: rtl/twi_line_filter.sv
module twi_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic line_clean
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_raw};
   end

   assign line_s = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_clean <= 1'b1;
            else        line_clean <= line_s;
         end
      end else begin : g_count
         localparam int CW = $clog2(FILT_CYCLES);
         logic [CW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q      <= '0;
               line_clean <= 1'b1;
            end else if (line_s == line_clean) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_CYCLES - 1)) begin
               run_q      <= '0;
               line_clean <= line_s;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_c,
   input  logic sda_c,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_c;
         sda_q <= sda_c;
      end
   end

   assign scl_rise = scl_c & ~scl_q;
   assign scl_fall = ~scl_c & scl_q;
   assign start_ev = scl_c & scl_q & sda_q & ~sda_c;
   assign stop_ev  = scl_c & scl_q & ~sda_q & sda_c;
endmodule

// File: rtl/twi_slave_ctrl.sv
module twi_slave_ctrl
   import twi_poll_pkg::*;
#(
   parameter logic [3:0] DEV_TYPE = DEF_DEV_TYPE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic              sda_c,
   input  logic [3:0]        strap_addr,
   input  logic              nv_busy,
   input  logic              data_ack_en,
   input  logic              read_req,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              drive_low,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_is_cmd,
   output logic              bus_stop,
   output twi_state_e        state,
   output logic [1:0]        byte_idx
);
   localparam int BC_W = $clog2(BYTE_W + 1);

   logic [BYTE_W-1:0] sh_q;
   logic [BC_W-1:0]   bit_q;
   logic              want_ack;

   always_comb begin
      case (byte_idx)
         2'd0:    want_ack = (sh_q == {DEV_TYPE, strap_addr}) && !nv_busy;
         2'd1:    want_ack = 1'b1;
         default: want_ack = data_ack_en;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         sh_q      <= '0;
         bit_q     <= '0;
         byte_idx  <= '0;
         drive_low <= 1'b0;
         rx_valid  <= 1'b0;
         rx_byte   <= '0;
         rx_is_cmd <= 1'b0;
         bus_stop  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         bus_stop <= 1'b0;
         if (start_ev) begin
            state     <= ST_RECV;
            bit_q     <= '0;
            byte_idx  <= '0;
            drive_low <= 1'b0;
         end else if (stop_ev) begin
            state     <= ST_IDLE;
            drive_low <= 1'b0;
            bus_stop  <= 1'b1;
         end else begin
            case (state)
               ST_RECV: begin
                  if (scl_rise) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_c};
                     bit_q <= bit_q + 1'b1;
                     if (bit_q == BC_W'(BYTE_W - 1) && byte_idx != 2'd0) begin
                        rx_valid  <= 1'b1;
                        rx_byte   <= {sh_q[BYTE_W-2:0], sda_c};
                        rx_is_cmd <= (byte_idx == 2'd1);
                     end
                  end
                  if (scl_fall && bit_q == BC_W'(BYTE_W)) begin
                     if (want_ack) begin
                        drive_low <= 1'b1;
                        state     <= ST_ACK;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bit_q <= '0;
                     if (byte_idx == 2'd1 && read_req) begin
                        sh_q      <= tx_byte;
                        drive_low <= ~tx_byte[BYTE_W-1];
                        state     <= ST_SEND;
                     end else begin
                        drive_low <= 1'b0;
                        state     <= ST_RECV;
                        if (byte_idx != 2'd2) byte_idx <= byte_idx + 2'd1;
                     end
                  end
               end
               ST_SEND: begin
                  if (scl_fall) begin
                     if (bit_q == BC_W'(BYTE_W - 1)) begin
                        drive_low <= 1'b0;
                        state     <= ST_SKIP;
                     end else begin
                        sh_q      <= {sh_q[BYTE_W-2:0], 1'b0};
                        drive_low <= ~sh_q[BYTE_W-2];
                        bit_q     <= bit_q + 1'b1;
                     end
                  end
               end
               default: drive_low <= 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/twi_poll_slave.sv
module twi_poll_slave
   import twi_poll_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_CYCLES = 4,
   parameter logic [3:0] DEV_TYPE    = DEF_DEV_TYPE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low,
   input  logic [3:0]        strap_addr,
   input  logic              nv_busy,
   input  logic              data_ack_en,
   input  logic              read_req,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              rx_is_cmd,
   output logic              bus_stop
);
   localparam int N_LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FILT_CYCLES < 1) begin : g_bad_filt
      $error("FILT_CYCLES must be at least 1");
   end

   logic [N_LINES-1:0] raw_vec, clean_vec;
   logic               scl_rise, scl_fall, start_ev, stop_ev;
   twi_state_e         ctl_state;
   logic [1:0]         ctl_idx;

   assign raw_vec = {sda_i, scl_i};

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      twi_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_CYCLES (FILT_CYCLES)
      ) u_filt (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_raw   (raw_vec[g]),
         .line_clean (clean_vec[g])
      );
   end

   twi_bus_events u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_c    (clean_vec[0]),
      .sda_c    (clean_vec[1]),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   twi_slave_ctrl #(
      .DEV_TYPE (DEV_TYPE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_rise    (scl_rise),
      .scl_fall    (scl_fall),
      .start_ev    (start_ev),
      .stop_ev     (stop_ev),
      .sda_c       (clean_vec[1]),
      .strap_addr  (strap_addr),
      .nv_busy     (nv_busy),
      .data_ack_en (data_ack_en),
      .read_req    (read_req),
      .tx_byte     (tx_byte),
      .drive_low   (sda_drive_low),
      .rx_valid    (rx_valid),
      .rx_byte     (rx_byte),
      .rx_is_cmd   (rx_is_cmd),
      .bus_stop    (bus_stop),
      .state       (ctl_state),
      .byte_idx    (ctl_idx)
   );
endmodule

// File: rtl/twi_poll_slave_chk.sv
module twi_poll_slave_chk
   import twi_poll_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_drive_low,
   input logic       nv_busy,
   input logic       rx_valid,
   input logic       bus_stop,
   input twi_state_e ctl_state,
   input logic [1:0] ctl_idx
);
   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !scl_i);                                  // R11

   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_drive_low) && ctl_idx == 2'd0) |-> !$past(nv_busy));       // R6

   AST_RX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);                                              // R4

   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |-> !sda_drive_low);                                         // R10

   AST_QUIET_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_state == ST_IDLE || ctl_state == ST_SKIP) |-> !sda_drive_low);   // R2
endmodule

bind twi_poll_slave twi_poll_slave_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_i         (scl_i),
   .sda_drive_low (sda_drive_low),
   .nv_busy       (nv_busy),
   .rx_valid      (rx_valid),
   .bus_stop      (bus_stop),
   .ctl_state     (ctl_state),
   .ctl_idx       (ctl_idx)
);

// File: tb/twi_poll_slave_test.sv
module twi_poll_slave_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 20;
   localparam int Q          = HALF / 2;
   localparam logic [3:0] STRAP = 4'hA;
   localparam logic [7:0] ADDR  = {4'b0101, STRAP};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic sda_line;
   logic sda_drive_low;
   logic nv_busy = 1'b0, data_ack_en = 1'b1, read_req = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic rx_valid, rx_is_cmd, bus_stop;
   logic [7:0] rx_byte;

   int checks = 0, errors = 0;
   int rx_n = 0, stop_n = 0, viol_n = 0;
   logic [7:0] last_rx = 8'h00;
   logic last_cmd = 1'b0;
   logic prev_drv = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign sda_line = m_sda & ~sda_drive_low;

   twi_poll_slave uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (m_scl),
      .sda_i         (sda_line),
      .sda_drive_low (sda_drive_low),
      .strap_addr    (STRAP),
      .nv_busy       (nv_busy),
      .data_ack_en   (data_ack_en),
      .read_req      (read_req),
      .tx_byte       (tx_byte),
      .rx_valid      (rx_valid),
      .rx_byte       (rx_byte),
      .rx_is_cmd     (rx_is_cmd),
      .bus_stop      (bus_stop)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rx_valid) begin
            rx_n     = rx_n + 1;
            last_rx  = rx_byte;
            last_cmd = rx_is_cmd;
         end
         if (bus_stop) stop_n = stop_n + 1;
         if (m_scl && sda_drive_low != prev_drv) viol_n = viol_n + 1;
      end
      prev_drv = sda_drive_low;
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_scl = 1'b0; wt(Q);
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1; wt(HALF);
      m_sda = 1'b0; wt(HALF);
      m_scl = 1'b0; wt(Q);
   endtask

   task automatic bus_end();
      m_scl = 1'b0; wt(Q);
      m_sda = 1'b0; wt(Q);
      m_scl = 1'b1; wt(HALF);
      m_sda = 1'b1; wt(HALF);
   endtask

   // glitch_bit in 0..7 inverts SDA for two clocks in that bit's high phase
   task automatic send_byte(input logic [7:0] b, input int glitch_bit,
                            output bit acked, output bit drv_seen);
      drv_seen = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         m_scl = 1'b0; wt(Q);
         m_sda = b[i]; wt(Q);
         m_scl = 1'b1;
         if (i == glitch_bit) begin
            wt(5); m_sda = ~b[i]; wt(2); m_sda = b[i]; wt(HALF - 7);
         end else begin
            wt(Q);
            if (sda_drive_low) drv_seen = 1'b1;
            wt(Q);
         end
      end
      m_scl = 1'b0; wt(Q);
      m_sda = 1'b1; wt(Q);
      m_scl = 1'b1; wt(Q);
      acked = sda_drive_low;
      wt(Q);
   endtask

   task automatic send_nibble(input logic [3:0] b);
      for (int i = 3; i >= 0; i--) begin
         m_scl = 1'b0; wt(Q);
         m_sda = b[i]; wt(Q);
         m_scl = 1'b1; wt(HALF);
      end
   endtask

   task automatic read_byte(input bit mack, output logic [7:0] b, output bit drv9);
      for (int i = 7; i >= 0; i--) begin
         m_scl = 1'b0; wt(Q);
         m_sda = 1'b1; wt(Q);
         m_scl = 1'b1; wt(Q);
         b[i] = sda_line;
         wt(Q);
      end
      m_scl = 1'b0; wt(Q);
      m_sda = mack ? 1'b0 : 1'b1; wt(Q);
      m_scl = 1'b1; wt(Q);
      drv9 = sda_drive_low;
      wt(Q);
   endtask

   task automatic t_reset();
      chk(sda_drive_low == 1'b0, "R10 reset drive", int'(sda_drive_low), 0);
      chk(rx_valid == 1'b0 && bus_stop == 1'b0, "R4 reset strobes", int'({rx_valid, bus_stop}), 0);
   endtask

   task automatic t_no_start();
      bit a, d;
      int n0 = rx_n;
      send_byte(ADDR, -1, a, d);
      chk(a == 1'b0, "R1 address without start acked", int'(a), 0);
      send_byte(8'h90, -1, a, d);
      chk(a == 1'b0 && rx_n == n0, "R1 byte without start", rx_n - n0, 0);
      bus_end();
   endtask

   task automatic t_write();
      bit a, d;
      int n0, s0 = stop_n;
      bus_start();
      send_byte(ADDR, -1, a, d);
      chk(a == 1'b1, "R2 matching address ack", int'(a), 1);
      chk(d == 1'b0, "R3 no drive during address bits", int'(d), 0);
      n0 = rx_n;
      send_byte(8'hA5, -1, a, d);
      chk(a == 1'b1, "R4 command ack", int'(a), 1);
      chk(rx_n == n0 + 1 && last_rx == 8'hA5 && last_cmd, "R4 command delivered",
          int'({last_cmd, last_rx}), 32'h1A5);
      data_ack_en = 1'b1;
      send_byte(8'h3C, -1, a, d);
      chk(a == 1'b1, "R5 data ack", int'(a), 1);
      chk(rx_n == n0 + 2 && last_rx == 8'h3C && !last_cmd, "R5 data delivered",
          int'({last_cmd, last_rx}), 32'h03C);
      bus_end();
      chk(stop_n == s0 + 1, "R10 stop pulse", stop_n - s0, 1);
      chk(sda_drive_low == 1'b0, "R10 released after stop", int'(sda_drive_low), 0);
   endtask

   task automatic t_data_refused();
      bit a, d;
      int n0;
      bus_start();
      send_byte(ADDR, -1, a, d);
      send_byte(8'h11, -1, a, d);
      data_ack_en = 1'b0;
      send_byte(8'h77, -1, a, d);
      chk(a == 1'b0, "R5 refused data not acked", int'(a), 0);
      data_ack_en = 1'b1;
      n0 = rx_n;
      send_byte(8'h55, -1, a, d);
      chk(a == 1'b0 && rx_n == n0, "R5 bus ignored after refusal", rx_n - n0, 0);
      bus_end();
   endtask

   task automatic t_mismatch();
      bit a, d;
      int n0;
      bus_start();
      send_byte({4'b0101, 4'h3}, -1, a, d);
      chk(a == 1'b0, "R2 strap mismatch", int'(a), 0);
      n0 = rx_n;
      send_byte(8'hC3, -1, a, d);
      chk(a == 1'b0 && d == 1'b0 && rx_n == n0, "R2 ignored after mismatch", rx_n - n0, 0);
      bus_end();
      bus_start();
      send_byte({4'b0110, STRAP}, -1, a, d);
      chk(a == 1'b0, "R2 type mismatch", int'(a), 0);
      bus_end();
   endtask

   task automatic t_busy();
      bit a, d;
      nv_busy = 1'b1;
      bus_start();
      send_byte(ADDR, -1, a, d);
      chk(a == 1'b0, "R6 no ack while busy", int'(a), 0);
      bus_end();
      nv_busy = 1'b0;
      bus_start();
      send_byte(ADDR, -1, a, d);
      chk(a == 1'b1, "R6 ack after busy clears", int'(a), 1);
      bus_end();
   endtask

   task automatic t_read(input logic [7:0] v, input bit mack);
      bit a, d, d9;
      logic [7:0] got;
      read_req = 1'b1;
      tx_byte  = v;
      bus_start();
      send_byte(ADDR, -1, a, d);
      send_byte(8'h90, -1, a, d);
      chk(a == 1'b1, "R4 read command ack", int'(a), 1);
      read_byte(mack, got, d9);
      read_req = 1'b0;
      chk(got == v, "R7 read byte", int'(got), int'(v));
      chk(d9 == 1'b0, "R7 released on ninth clock", int'(d9), 0);
      send_byte(8'hFF, -1, a, d);
      chk(a == 1'b0 && d == 1'b0, "R7 silent after read", int'({a, d}), 0);
      bus_end();
   endtask

   task automatic t_restart();
      bit a, d;
      bus_start();
      send_nibble(4'h5);
      bus_start();
      send_byte(ADDR, -1, a, d);
      chk(a == 1'b1, "R8 address after mid-byte start", int'(a), 1);
      send_byte(8'h6E, -1, a, d);
      chk(a == 1'b1 && last_rx == 8'h6E && last_cmd, "R8 command after restart",
          int'(last_rx), 32'h6E);
      bus_end();
   endtask

   task automatic t_glitch();
      bit a, d;
      int n0;
      bus_start();
      send_byte(ADDR, -1, a, d);
      n0 = rx_n;
      send_byte(8'h96, 4, a, d);
      chk(a == 1'b1 && last_rx == 8'h96 && rx_n == n0 + 1, "R9 low glitch filtered",
          int'(last_rx), 32'h96);
      send_byte(8'h00, 3, a, d);
      chk(a == 1'b1 && last_rx == 8'h00 && rx_n == n0 + 2, "R9 high glitch filtered",
          int'(last_rx), 0);
      bus_end();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(5);
      t_reset();
      t_no_start();
      t_write();
      t_data_refused();
      t_mismatch();
      t_busy();
      t_read(8'hC6, 1'b1);
      t_read(8'h3B, 1'b0);
      t_restart();
      t_glitch();
      chk(viol_n == 0, "R11 drive changed with SCL high", viol_n, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule